// File: doc/BRIEF.md
# Frame Base Address and Flag-Set Execution Unit

This unit executes one opcode group of a 32-bit processor whose local registers form a circular window cached from the memory stack. A decoded instruction arrives as a 5-bit selector, a destination kind, the stack pointer, the status word and the four condition flags. From these the unit either rebuilds the byte address where the first local register of the current frame would live in memory, writes a full-width true/false mask derived from the flags, requests a fetch, or reports an illegal encoding.

The frame pointer is the top seven bits of the status word. The frame base address takes the upper stack-pointer bits from bit 9 upward, places the frame pointer below them on a word boundary, and adds a correction at bit 9. That correction fixes the case where the stack pointer has already moved past a 512-byte boundary that the frame pointer has not yet crossed. The unit has no flag or status output, so flags and the frame pointer always stay unchanged. Every result is registered once.

Top module: `setop_unit`

## Requirements
- R1: `dst_sel` encodes 2'b00 general register, 2'b01 status register, 2'b10 program counter, 2'b11 unused. A general destination with `n_sel` = 0 selects the frame base operation. A general destination with `n_sel` from 1 to 31 selects the flag-set operation.
- R2: The frame base result is {sp_in[31:9], sr_in[31:25], 2'b00} plus the correction term at bit 9. `wb_en` is high.
- R3: The correction at bit 9 is 1 exactly when sp_in[8] is 1 and sr_in[31] is 0. Otherwise it is 0.
- R4: The frame base addition is modulo 2^32. A carry out of bit 31 is dropped, so an all-ones upper stack pointer that receives the correction yields zero.
- R5: The flag-set operation writes 32'hFFFFFFFF when its condition holds and 32'h0 when it does not. `wb_en` is high.
- R6: `flags_in` bits are C = bit 0, Z = bit 1, N = bit 2, V = bit 3. The condition is P(n_sel[4:1]) XOR n_sel[0]. P is indexed 0..15 as: 1, Z, C, N, V, C|Z, N^V, (N^V)|Z, Z&C, Z|N, C&~Z, N&V, N|V, C^V, Z^N, C|V.
- R7: A status-register destination raises `fetch_req` for exactly one cycle, with `wb_en` low, for any `n_sel`.
- R8: A program-counter or unused destination raises `illegal_op` with `wb_en` low, for any `n_sel`.
- R9: Outputs appear on the clock edge after the input is accepted. A cycle with `in_valid` low yields all outputs low on the next edge.
- R10: `wb_data` is zero whenever `wb_en` is low.
- R11: While `rst` is high at a clock edge, all outputs go to zero regardless of inputs.
- R12: At most one of `wb_en`, `fetch_req` and `illegal_op` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Decoded instruction present |
| n_sel | input | 5 | Operation selector field |
| dst_sel | input | 2 | Destination kind |
| sp_in | input | 32 | Stack pointer |
| sr_in | input | 32 | Status word, frame pointer in bits 31..25 |
| flags_in | input | 4 | Condition flags {V,N,Z,C} |
| wb_en | output | 1 | Register write enable |
| wb_data | output | 32 | Write-back value |
| fetch_req | output | 1 | One-cycle fetch request |
| illegal_op | output | 1 | Reserved encoding seen |

## Verification
A wrong decode of the destination kind or `n_sel` is visible one edge after the input, as the wrong one of the three strobes. A wrong correction decision shows in bit 9 of `wb_data` and in the bits above it through the carry ripple, or as a non-zero result for the all-ones wrap case. A wrong condition table row is visible as an inverted mask for one flag pattern. For this reason every selector value is driven with several flag patterns and compared with an independently written model.

// File: rtl/setop_pkg.sv
package setop_pkg;
  localparam int unsigned N_W    = 5;
  localparam int unsigned FLAG_W = 4;
  localparam int unsigned FLG_C  = 0;
  localparam int unsigned FLG_Z  = 1;
  localparam int unsigned FLG_N  = 2;
  localparam int unsigned FLG_V  = 3;

  typedef enum logic [1:0] {
    DST_GPR = 2'b00,
    DST_SR  = 2'b01,
    DST_PC  = 2'b10,
    DST_RSV = 2'b11
  } dst_e;
endpackage

// File: rtl/setop_decode.sv
module setop_decode
  import setop_pkg::*;
(
  input  logic           valid,
  input  logic [N_W-1:0] n_sel,
  input  logic [1:0]     dst_sel,
  output logic           is_adr,
  output logic           is_cond,
  output logic           is_fetch,
  output logic           is_illegal
);
  logic to_gpr;
  logic n_zero;

  assign to_gpr = (dst_e'(dst_sel) == DST_GPR);
  assign n_zero = (n_sel == '0);

  assign is_adr     = valid & to_gpr & n_zero;
  assign is_cond    = valid & to_gpr & ~n_zero;
  assign is_fetch   = valid & (dst_e'(dst_sel) == DST_SR);
  assign is_illegal = valid & ((dst_e'(dst_sel) == DST_PC) | (dst_e'(dst_sel) == DST_RSV));
endmodule

// File: rtl/setop_frame_addr.sv
module setop_frame_addr #(
  parameter int unsigned XLEN  = 32,
  parameter int unsigned FP_W  = 7,
  parameter int unsigned ALIGN = 2
) (
  input  logic [XLEN-1:0] sp,
  input  logic [XLEN-1:0] sr,
  output logic            carry,
  output logic [XLEN-1:0] addr
);
  localparam int unsigned CPOS = FP_W + ALIGN;

  function automatic logic wrap_fix(input logic [XLEN-1:0] s_p, input logic [XLEN-1:0] s_r);
    return s_p[CPOS-1] & ~s_r[XLEN-1];
  endfunction

  function automatic logic [XLEN-1:0] base_join(input logic [XLEN-1:0] s_p,
                                                input logic [XLEN-1:0] s_r,
                                                input logic            c);
    logic [XLEN-1:0] joined;
    joined = {s_p[XLEN-1:CPOS], s_r[XLEN-1 -: FP_W], {ALIGN{1'b0}}};
    return joined + (XLEN'(c) << CPOS);
  endfunction

  assign carry = wrap_fix(sp, sr);
  assign addr  = base_join(sp, sr, carry);

  logic unused_bits;
  assign unused_bits = ^{sp[CPOS-2:0], sr[XLEN-FP_W-1:0]};
endmodule

// File: rtl/setop_cond.sv
module setop_cond
  import setop_pkg::*;
(
  input  logic [N_W-1:0]    n_sel,
  input  logic [FLAG_W-1:0] flags,
  output logic              hit
);
  localparam int unsigned NCODE = 1 << N_W;
  localparam int unsigned NPRED = NCODE / 2;

  logic c, z, n, v;
  logic [NPRED-1:0] pred;
  logic [NCODE-1:0] hit_vec;

  assign c = flags[FLG_C];
  assign z = flags[FLG_Z];
  assign n = flags[FLG_N];
  assign v = flags[FLG_V];

  always_comb begin
    pred     = '0;
    pred[0]  = 1'b1;
    pred[1]  = z;
    pred[2]  = c;
    pred[3]  = n;
    pred[4]  = v;
    pred[5]  = c | z;
    pred[6]  = n ^ v;
    pred[7]  = (n ^ v) | z;
    pred[8]  = z & c;
    pred[9]  = z | n;
    pred[10] = c & ~z;
    pred[11] = n & v;
    pred[12] = n | v;
    pred[13] = c ^ v;
    pred[14] = z ^ n;
    pred[15] = c | v;
  end

  for (genvar k = 0; k < NCODE; k++) begin : g_code
    assign hit_vec[k] = pred[k / 2] ^ ((k % 2) == 1);
  end

  assign hit = hit_vec[n_sel];
endmodule

// File: rtl/setop_unit.sv
module setop_unit
  import setop_pkg::*;
#(
  parameter int unsigned XLEN  = 32,
  parameter int unsigned FP_W  = 7,
  parameter int unsigned ALIGN = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [N_W-1:0]    n_sel,
  input  logic [1:0]        dst_sel,
  input  logic [XLEN-1:0]   sp_in,
  input  logic [XLEN-1:0]   sr_in,
  input  logic [FLAG_W-1:0] flags_in,
  output logic              wb_en,
  output logic [XLEN-1:0]   wb_data,
  output logic              fetch_req,
  output logic              illegal_op
);
  logic            op_adr;
  logic            op_cond;
  logic            op_fetch;
  logic            op_illegal;
  logic            adr_carry;
  logic [XLEN-1:0] adr_value;
  logic            cond_hit;
  logic [XLEN-1:0] next_data;

  setop_decode dec_i (
    .valid      (in_valid),
    .n_sel      (n_sel),
    .dst_sel    (dst_sel),
    .is_adr     (op_adr),
    .is_cond    (op_cond),
    .is_fetch   (op_fetch),
    .is_illegal (op_illegal)
  );

  setop_frame_addr #(.XLEN(XLEN), .FP_W(FP_W), .ALIGN(ALIGN)) fa_i (
    .sp    (sp_in),
    .sr    (sr_in),
    .carry (adr_carry),
    .addr  (adr_value)
  );

  setop_cond cond_i (
    .n_sel (n_sel),
    .flags (flags_in),
    .hit   (cond_hit)
  );

  always_comb begin
    next_data = '0;
    if (op_adr)       next_data = adr_value;
    else if (op_cond) next_data = {XLEN{cond_hit}};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wb_en      <= 1'b0;
      wb_data    <= '0;
      fetch_req  <= 1'b0;
      illegal_op <= 1'b0;
    end else begin
      wb_en      <= op_adr | op_cond;
      wb_data    <= next_data;
      fetch_req  <= op_fetch;
      illegal_op <= op_illegal;
    end
  end
endmodule

// File: rtl/setop_unit_chk.sv
module setop_unit_chk #(
  parameter int unsigned XLEN  = 32,
  parameter int unsigned FP_W  = 7,
  parameter int unsigned ALIGN = 2
) (
  input logic            clk,
  input logic            rst,
  input logic            in_valid,
  input logic            op_adr,
  input logic            op_cond,
  input logic            op_fetch,
  input logic            op_illegal,
  input logic            adr_carry,
  input logic [FP_W-1:0] sr_fp,
  input logic            sp_cbit,
  input logic            wb_en,
  input logic [XLEN-1:0] wb_data,
  input logic            fetch_req,
  input logic            illegal_op
);
  localparam int unsigned CPOS = FP_W + ALIGN;

  // R12
  one_kind_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({wb_en, fetch_req, illegal_op}));

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!wb_en && !fetch_req && !illegal_op));

  // R10
  data_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !wb_en |-> (wb_data == '0));

  // R2
  frame_field_chk: assert property (@(posedge clk) disable iff (rst)
    op_adr |=> (wb_en && wb_data[CPOS-1:ALIGN] == $past(sr_fp) && wb_data[ALIGN-1:0] == '0));

  // R3
  carry_bit_chk: assert property (@(posedge clk) disable iff (rst)
    op_adr |=> (wb_data[CPOS] == ($past(sp_cbit) ^ $past(adr_carry))));

  // R5
  cond_mask_chk: assert property (@(posedge clk) disable iff (rst)
    op_cond |=> (wb_en && (wb_data == '0 || wb_data == '1)));

  // R7
  fetch_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    op_fetch |=> (fetch_req && !wb_en));

  // R8
  illegal_flag_chk: assert property (@(posedge clk) disable iff (rst)
    op_illegal |=> (illegal_op && !wb_en));
endmodule

bind setop_unit setop_unit_chk #(.XLEN(XLEN), .FP_W(FP_W), .ALIGN(ALIGN)) chk_i (
  .clk        (clk),
  .rst        (rst),
  .in_valid   (in_valid),
  .op_adr     (op_adr),
  .op_cond    (op_cond),
  .op_fetch   (op_fetch),
  .op_illegal (op_illegal),
  .adr_carry  (adr_carry),
  .sr_fp      (sr_in[XLEN-1 -: FP_W]),
  .sp_cbit    (sp_in[FP_W + ALIGN]),
  .wb_en      (wb_en),
  .wb_data    (wb_data),
  .fetch_req  (fetch_req),
  .illegal_op (illegal_op)
);

// File: tb/setop_unit_tb.sv
`timescale 1ns/1ps
module setop_unit_tb_top;
  typedef struct packed {
    logic [4:0]  n;
    logic [1:0]  dst;
    logic [31:0] sp;
    logic [31:0] sr;
    logic [3:0]  fl;
    logic [1:0]  kind;   // 0 write, 1 fetch, 2 illegal
    logic [31:0] data;
  } vec_t;

  localparam int NVEC = 12;
  localparam vec_t VEC [NVEC] = '{
    '{5'd0,  2'b00, 32'h0000_0100, 32'h0000_0000, 4'h0,    2'd0, 32'h0000_0200},
    '{5'd0,  2'b00, 32'hFFFF_FF00, 32'h0000_0000, 4'h0,    2'd0, 32'h0000_0000},
    '{5'd0,  2'b00, 32'h1234_5700, 32'hFE00_0000, 4'h0,    2'd0, 32'h1234_57FC},
    '{5'd0,  2'b00, 32'h8000_0000, 32'h4000_0000, 4'h0,    2'd0, 32'h8000_0080},
    '{5'd0,  2'b00, 32'h0000_03FF, 32'h7E00_0000, 4'h0,    2'd0, 32'h0000_04FC},
    '{5'd0,  2'b00, 32'hFFFF_FFFF, 32'h01FF_FFFF, 4'h0,    2'd0, 32'h0000_0000},
    '{5'd1,  2'b00, 32'h0,         32'h0,         4'hF,    2'd0, 32'h0000_0000},
    '{5'd2,  2'b00, 32'h0,         32'h0,         4'b0010, 2'd0, 32'hFFFF_FFFF},
    '{5'd13, 2'b00, 32'h0,         32'h0,         4'b0100, 2'd0, 32'h0000_0000},
    '{5'd7,  2'b01, 32'h0000_0100, 32'h0,         4'h0,    2'd1, 32'h0000_0000},
    '{5'd0,  2'b10, 32'h0000_0100, 32'h0,         4'h0,    2'd2, 32'h0000_0000},
    '{5'd31, 2'b11, 32'h0,         32'h0,         4'hF,    2'd2, 32'h0000_0000}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [4:0]  n_sel = '0;
  logic [1:0]  dst_sel = '0;
  logic [31:0] sp_in = '0;
  logic [31:0] sr_in = '0;
  logic [3:0]  flags_in = '0;
  logic        wb_en, fetch_req, illegal_op;
  logic [31:0] wb_data;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  setop_unit dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .n_sel(n_sel), .dst_sel(dst_sel),
    .sp_in(sp_in), .sr_in(sr_in), .flags_in(flags_in),
    .wb_en(wb_en), .wb_data(wb_data), .fetch_req(fetch_req), .illegal_op(illegal_op)
  );

  function automatic logic [31:0] ref_frame(input logic [31:0] sp, input logic [31:0] sr);
    logic [32:0] acc;
    acc = {1'b0, (sp >> 9) << 9};
    acc = acc + (33'(sr >> 25) << 2);
    if (sp[8] == 1'b1 && sr[31] == 1'b0) acc = acc + 33'd512;
    return acc[31:0];
  endfunction

  function automatic logic ref_cond(input logic [4:0] n, input logic [3:0] f);
    logic c, z, ng, v, p;
    c = f[0]; z = f[1]; ng = f[2]; v = f[3];
    case (n >> 1)
      5'd0:  p = 1'b1;
      5'd1:  p = z;
      5'd2:  p = c;
      5'd3:  p = ng;
      5'd4:  p = v;
      5'd5:  p = c | z;
      5'd6:  p = ng ^ v;
      5'd7:  p = (ng ^ v) | z;
      5'd8:  p = z & c;
      5'd9:  p = z | ng;
      5'd10: p = c & ~z;
      5'd11: p = ng & v;
      5'd12: p = ng | v;
      5'd13: p = c ^ v;
      5'd14: p = z ^ ng;
      default: p = c | v;
    endcase
    return p ^ n[0];
  endfunction

  task automatic check(input string req, input logic ok, input logic [34:0] act, input logic [34:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [4:0] n, input logic [1:0] d, input logic [31:0] sp,
                       input logic [31:0] sr, input logic [3:0] f);
    n_sel = n; dst_sel = d; sp_in = sp; sr_in = sr; flags_in = f; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic expect_out(input string req, input logic e_wb, input logic e_f,
                            input logic e_il, input logic [31:0] e_d);
    logic [34:0] act, exp;
    act = {wb_en, fetch_req, illegal_op, wb_data};
    exp = {e_wb, e_f, e_il, e_d};
    check(req, act === exp, act, exp);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R9 watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // R11: reset holds outputs low with a live input
    n_sel = 5'd0; dst_sel = 2'b01; in_valid = 1'b1;
    repeat (3) @(negedge clk);
    expect_out("R11 reset", 1'b0, 1'b0, 1'b0, 32'h0);
    in_valid = 1'b0;
    rst = 1'b0;
    @(negedge clk);
    expect_out("R9 idle after reset", 1'b0, 1'b0, 1'b0, 32'h0);

    // Vector table: R1 R2 R3 R4 R5 R6 R7 R8
    for (int i = 0; i < NVEC; i++) begin
      drive(VEC[i].n, VEC[i].dst, VEC[i].sp, VEC[i].sr, VEC[i].fl);
      case (VEC[i].kind)
        2'd0:    expect_out("R2/R3/R4/R5 table write", 1'b1, 1'b0, 1'b0, VEC[i].data);
        2'd1:    expect_out("R7 table fetch", 1'b0, 1'b1, 1'b0, 32'h0);
        default: expect_out("R8 table illegal", 1'b0, 1'b0, 1'b1, 32'h0);
      endcase
    end

    // R6: every selector against the model under four flag patterns
    for (int nv = 1; nv < 32; nv++) begin
      for (int fv = 0; fv < 16; fv += 5) begin
        drive(5'(nv), 2'b00, 32'h0, 32'h0, 4'(fv));
        expect_out("R6 condition", 1'b1, 1'b0, 1'b0, {32{ref_cond(5'(nv), 4'(fv))}});
      end
    end

    // R1: frame base must not be chosen for nonzero n even with carry-prone operands
    drive(5'd1, 2'b00, 32'h0000_0100, 32'h0000_0000, 4'h0);
    expect_out("R1 n=1 is flag-set", 1'b1, 1'b0, 1'b0, 32'h0);

    // R3: mixed operand sweep against the model
    for (int k = 0; k < 8; k++) begin
      logic [31:0] sp, sr;
      sp = 32'h9E37_79B9 * (k + 1);
      sr = 32'h7F4A_7C15 * (k + 3);
      drive(5'd0, 2'b00, sp, sr, 4'h0);
      expect_out("R3 frame sweep", 1'b1, 1'b0, 1'b0, ref_frame(sp, sr));
    end

    // R7: fetch lasts one cycle only, for a nonzero n
    drive(5'd19, 2'b01, 32'h0, 32'h0, 4'h0);
    expect_out("R7 fetch pulse", 1'b0, 1'b1, 1'b0, 32'h0);
    @(negedge clk);
    expect_out("R7 fetch drops", 1'b0, 1'b0, 1'b0, 32'h0);

    // R9/R10: a write followed by an idle cycle
    drive(5'd0, 2'b00, 32'h0000_0100, 32'h0, 4'h0);
    expect_out("R9 latency", 1'b1, 1'b0, 1'b0, 32'h0000_0200);
    @(negedge clk);
    expect_out("R10 idle data zero", 1'b0, 1'b0, 1'b0, 32'h0);

    // R8: program counter destination with n = 5
    drive(5'd5, 2'b10, 32'h0, 32'h0, 4'hF);
    expect_out("R8 pc reserved", 1'b0, 1'b0, 1'b1, 32'h0);

    // R11: reset mid-stream clears a pending write
    n_sel = 5'd2; dst_sel = 2'b00; flags_in = 4'b0010; in_valid = 1'b1; rst = 1'b1;
    @(negedge clk);
    expect_out("R11 reset mid-stream", 1'b0, 1'b0, 1'b0, 32'h0);
    in_valid = 1'b0; rst = 1'b0;
    @(negedge clk);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule